// File: doc/BRIEF.md
# Debug Flag and Buffer Registers

This block is the processor-side register pair of a debug and in-system-programming link driven through a TAP. A flag register carries a program-enable bit, a two-bit loader source field and a transfer-done flag. A data buffer register serves as the parallel holding side of the TAP debug shift register. The processor reads and writes both registers through a simple port with per-bit write enables. The TAP side supplies its own program-enable copy, a shift-done strobe and a parallel capture path into the buffer. A debug-engine strobe clears the transfer-done flag.

The program-enable bit that the processor sees is the OR of a processor-written copy and the TAP copy. The processor copy survives ordinary system resets. Only power-on reset or Test-Logic-Reset clears it, and the ROD input clears it at any time. A processor write that touches either control bit (program-enable or transfer-done) wipes the source field. The block decodes the source field into three loader-mode outputs, and these are live only while program-enable is set.

Top module: `dbg_link_regs`

## Requirements
- R1: While `por_n` is low and after it is released, the flag read value, the buffer, `prog_en`, `xfer_done` and `src_sel` are all 0.
- R2: Reading the flag register (`cpu_sel`=0) returns bits 7:4 and all bits above them as 0, whatever was written.
- R3: Flag bit 1 on read and `prog_en` both equal the OR of the processor copy of program-enable and `tap_spe`.
- R4: The processor copy of program-enable (written through flag bit 1) is cleared by `por_n` low or by a `tlr` pulse, and it is kept through a `sys_rst` pulse.
- R5: When `rod` is high at a clock edge, the processor copy of program-enable is 0 after that edge, even if a processor write of 1 to it occurs in the same cycle.
- R6: A processor flag write whose mask includes bit 1 or bit 0 leaves `src_sel` (flag bits 3:2) at 00 after the edge, whatever data is written, and this takes priority over source bits written in the same access.
- R7: A flag write with only bits 3:2 enabled loads `src_sel`. While `prog_en` is 1 the source value 00 raises `ld_jtag`, 01 raises `ld_i2c`, and 10 or 11 raises `ld_exit`. While `prog_en` is 0, all three outputs are 0.
- R8: `tap_shift_done` sets `xfer_done` (flag bit 0) and `eng_clr_txc` clears it. When both occur in the same cycle, the set wins.
- R9: Buffer writes (`cpu_sel`=1) update only the bits enabled in `cpu_wmask`. The buffer value appears on `buf_par` and reads back on `cpu_rdata`.
- R10: `tap_cap_en` loads `tap_cap_data` into the buffer, and it overrides a processor buffer write in the same cycle.
- R11: A `sys_rst` pulse clears `xfer_done`, `src_sel` and the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tlr | input | 1 | Synchronous Test-Logic-Reset pulse |
| sys_rst | input | 1 | Synchronous system reset pulse |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 1 | Register select: 0 flag, 1 buffer |
| cpu_wmask | input | DATA_W | Per-bit write enable |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data of the selected register |
| tap_spe | input | 1 | TAP-side program-enable copy |
| tap_shift_done | input | 1 | End-of-shift strobe |
| tap_cap_en | input | 1 | Parallel load of the buffer from the TAP |
| tap_cap_data | input | DATA_W | TAP parallel data |
| buf_par | output | DATA_W | Buffer contents to the TAP shift register |
| eng_clr_txc | input | 1 | Debug-engine clear of transfer-done |
| rod | input | 1 | Clears processor program-enable |
| prog_en | output | 1 | Effective program-enable |
| src_sel | output | 2 | Raw loader source field |
| xfer_done | output | 1 | Transfer-done flag |
| ld_jtag | output | 1 | Loader mode: JTAG |
| ld_i2c | output | 1 | Loader mode: I2C |
| ld_exit | output | 1 | Loader mode: exit |

## Verification
The hardest cases to reach are collisions within a single cycle. These include a processor write that sets program-enable while `rod` fires, and a flag write whose mask covers both the source field and a control bit. Other collisions are a capture landing on a processor buffer write, and a shift-done strobe meeting the engine clear. The bench drives each pair of inputs together for exactly one cycle. It then reads the result back through the flag and buffer ports. A second set of cases separates the two program-enable copies. The bench holds `tap_spe` low and applies `sys_rst`, `tlr` and `rod` one after another, so that only the processor copy is observed.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
    localparam int FLAG_W   = 8;
    localparam int TXC_BIT  = 0;
    localparam int SPE_BIT  = 1;
    localparam int SRC_LO   = 2;
    localparam int SRC_W    = 2;
    localparam int CTL_BITS = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_JTAG = 2'b00,
        SRC_I2C  = 2'b01,
        SRC_EXIT = 2'b10
    } src_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             spe;
        logic             txc;
    } flag_t;
endpackage

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg
    import dbg_link_pkg::*;
(
    input  logic                clk,
    input  logic                por_n,
    input  logic                tlr,
    input  logic                sys_rst,
    input  logic                wr_en,
    input  logic [CTL_BITS-1:0] wmask,
    input  logic [CTL_BITS-1:0] wdata,
    input  logic                tap_spe,
    input  logic                shift_done,
    input  logic                eng_clr,
    input  logic                rod,
    output flag_t               flag_q,
    output logic                spe_eff
);
    flag_t state_d, state_q;
    logic  ctl_touch;

    always_comb begin
        state_d   = state_q;
        ctl_touch = wr_en && (wmask[TXC_BIT] || wmask[SPE_BIT]);

        // transfer-done: hardware set > engine clear > processor write
        if (shift_done)
            state_d.txc = 1'b1;
        else if (eng_clr)
            state_d.txc = 1'b0;
        else if (wr_en && wmask[TXC_BIT])
            state_d.txc = wdata[TXC_BIT];

        // source field: per-bit write, wiped by any control-bit write
        for (int i = 0; i < SRC_W; i++) begin
            if (wr_en && wmask[SRC_LO+i])
                state_d.src[i] = wdata[SRC_LO+i];
        end
        if (ctl_touch)
            state_d.src = '0;

        // processor program-enable copy: ROD beats write
        if (rod)
            state_d.spe = 1'b0;
        else if (wr_en && wmask[SPE_BIT])
            state_d.spe = wdata[SPE_BIT];
        if (tlr)
            state_d.spe = 1'b0;

        // system reset leaves the program-enable copy alone
        if (sys_rst) begin
            state_d.txc = 1'b0;
            state_d.src = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign flag_q  = state_q;
    assign spe_eff = state_q.spe | tap_spe;
endmodule

// File: rtl/dbg_buf_reg.sv
module dbg_buf_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    output logic [W-1:0] buf_q
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (sys_rst)
            data_d = '0;
        else if (cap_en)
            data_d = cap_data;
        else if (wr_en)
            data_d = (data_q & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            data_q <= '0;
        else
            data_q <= data_d;
    end

    assign buf_q = data_q;
endmodule

// File: rtl/dbg_src_decode.sv
module dbg_src_decode
    import dbg_link_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    input  logic             enable,
    output logic             ld_jtag,
    output logic             ld_i2c,
    output logic             ld_exit
);
    always_comb begin
        ld_jtag = 1'b0;
        ld_i2c  = 1'b0;
        ld_exit = 1'b0;
        if (enable) begin
            if (src[1])
                ld_exit = 1'b1;
            else if (src == SRC_I2C)
                ld_i2c = 1'b1;
            else
                ld_jtag = 1'b1;
        end
    end
endmodule

// File: rtl/dbg_link_regs.sv
module dbg_link_regs
    import dbg_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tlr,
    input  logic              sys_rst,
    input  logic              cpu_wr,
    input  logic              cpu_sel,
    input  logic [DATA_W-1:0] cpu_wmask,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tap_spe,
    input  logic              tap_shift_done,
    input  logic              tap_cap_en,
    input  logic [DATA_W-1:0] tap_cap_data,
    output logic [DATA_W-1:0] buf_par,
    input  logic              eng_clr_txc,
    input  logic              rod,
    output logic              prog_en,
    output logic [1:0]        src_sel,
    output logic              xfer_done,
    output logic              ld_jtag,
    output logic              ld_i2c,
    output logic              ld_exit
);
    localparam int PAD_W = DATA_W - CTL_BITS;

    flag_t flag_q;
    logic  spe_eff;
    logic  flag_wr, buf_wr;

    assign flag_wr = cpu_wr && !cpu_sel;
    assign buf_wr  = cpu_wr &&  cpu_sel;

    dbg_flag_reg u_flag (
        .clk        (clk),
        .por_n      (por_n),
        .tlr        (tlr),
        .sys_rst    (sys_rst),
        .wr_en      (flag_wr),
        .wmask      (cpu_wmask[CTL_BITS-1:0]),
        .wdata      (cpu_wdata[CTL_BITS-1:0]),
        .tap_spe    (tap_spe),
        .shift_done (tap_shift_done),
        .eng_clr    (eng_clr_txc),
        .rod        (rod),
        .flag_q     (flag_q),
        .spe_eff    (spe_eff)
    );

    dbg_buf_reg #(.W(DATA_W)) u_buf (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst  (sys_rst),
        .wr_en    (buf_wr),
        .wmask    (cpu_wmask),
        .wdata    (cpu_wdata),
        .cap_en   (tap_cap_en),
        .cap_data (tap_cap_data),
        .buf_q    (buf_par)
    );

    dbg_src_decode u_dec (
        .src     (flag_q.src),
        .enable  (spe_eff),
        .ld_jtag (ld_jtag),
        .ld_i2c  (ld_i2c),
        .ld_exit (ld_exit)
    );

    always_comb begin
        if (cpu_sel)
            cpu_rdata = buf_par;
        else
            cpu_rdata = {{PAD_W{1'b0}}, flag_q.src, spe_eff, flag_q.txc};
    end

    assign prog_en   = spe_eff;
    assign src_sel   = flag_q.src;
    assign xfer_done = flag_q.txc;
endmodule

// File: rtl/dbg_link_regs_chk.sv
module dbg_link_regs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst,
    input logic              cpu_wr,
    input logic              cpu_sel,
    input logic [DATA_W-1:0] cpu_wmask,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              tap_spe,
    input logic              tap_shift_done,
    input logic              tap_cap_en,
    input logic [DATA_W-1:0] tap_cap_data,
    input logic [DATA_W-1:0] buf_par,
    input logic              rod,
    input logic              prog_en,
    input logic [1:0]        src_sel,
    input logic              xfer_done,
    input logic              ld_jtag,
    input logic              ld_i2c,
    input logic              ld_exit
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        !cpu_sel |-> cpu_rdata[DATA_W-1:4] == '0);

    a_r5_rod_clears: assert property (@(posedge clk) disable iff (!por_n)
        rod |=> prog_en == tap_spe);

    a_r6_src_wipe: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_wr && !cpu_sel && (cpu_wmask[0] || cpu_wmask[1])) |=> src_sel == 2'b00);

    a_r7_modes_gated: assert property (@(posedge clk) disable iff (!por_n)
        !prog_en |-> !(ld_jtag || ld_i2c || ld_exit));

    a_r7_modes_onehot: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({ld_jtag, ld_i2c, ld_exit}));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        (tap_shift_done && !sys_rst) |=> xfer_done);

    a_r10_capture_wins: assert property (@(posedge clk) disable iff (!por_n)
        (tap_cap_en && !sys_rst) |=> buf_par == $past(tap_cap_data));
endmodule

bind dbg_link_regs dbg_link_regs_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dbg_link_regs_tb_top.sv
module dbg_link_regs_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          por_n, tlr, sys_rst, cpu_wr, cpu_sel;
    logic [DW-1:0] cpu_wmask, cpu_wdata, cpu_rdata;
    logic          tap_spe, tap_shift_done, tap_cap_en;
    logic [DW-1:0] tap_cap_data, buf_par;
    logic          eng_clr_txc, rod, prog_en, xfer_done;
    logic [1:0]    src_sel;
    logic          ld_jtag, ld_i2c, ld_exit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_link_regs #(.DATA_W(DW)) dut_i (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tlr = 0; sys_rst = 0; cpu_wr = 0; cpu_wmask = '0; cpu_wdata = '0;
        tap_shift_done = 0; tap_cap_en = 0; eng_clr_txc = 0; rod = 0;
    endtask

    task automatic wr(input logic sel, input logic [DW-1:0] m, input logic [DW-1:0] d);
        cpu_wr = 1; cpu_sel = sel; cpu_wmask = m; cpu_wdata = d;
        tick();
        idle();
    endtask

    task automatic rd(input logic sel, output logic [DW-1:0] v);
        cpu_sel = sel;
        #1;
        v = cpu_rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(0, v); chk("R1 flag after por", v, 0);
        rd(1, v); chk("R1 buffer after por", v, 0);
        chk("R1 prog_en/xfer/src", {prog_en, xfer_done, src_sel}, 0);
    endtask

    task automatic t_reserved();
        logic [DW-1:0] v;
        wr(0, 8'hFF, 8'hFF);
        rd(0, v); chk("R2 R6 all-ones write", v, 8'h03);
        wr(0, 8'h03, 8'h00);
        rd(0, v); chk("R2 cleared", v, 8'h00);
    endtask

    task automatic t_src();
        logic [DW-1:0] v;
        wr(0, 8'h0C, 8'h04);
        chk("R7 src loaded", src_sel, 2'b01);
        chk("R7 gated off", {ld_jtag, ld_i2c, ld_exit}, 3'b000);
        tap_spe = 1; #1;
        rd(0, v); chk("R3 tap copy reads as 1", v, 8'h06);
        chk("R7 i2c mode", {ld_jtag, ld_i2c, ld_exit}, 3'b010);
        wr(0, 8'h0C, 8'h0C);
        chk("R7 exit mode 11", {ld_jtag, ld_i2c, ld_exit}, 3'b001);
        wr(0, 8'h0C, 8'h00);
        chk("R7 jtag mode", {ld_jtag, ld_i2c, ld_exit}, 3'b100);
        wr(0, 8'h0E, 8'h0C);
        chk("R6 spe-touch wins over src data", src_sel, 2'b00);
        tap_spe = 0; #1;
        chk("R3 both copies 0", prog_en, 0);
    endtask

    task automatic t_spe_resets();
        wr(0, 8'h02, 8'h02);
        chk("R3 cpu copy alone", prog_en, 1);
        sys_rst = 1; tick(); idle();
        chk("R4 kept through sys_rst", prog_en, 1);
        tlr = 1; tick(); idle();
        chk("R4 cleared by tlr", prog_en, 0);
    endtask

    task automatic t_rod();
        wr(0, 8'h02, 8'h02);
        rod = 1; cpu_wr = 1; cpu_sel = 0; cpu_wmask = 8'h02; cpu_wdata = 8'h02;
        tick(); idle();
        chk("R5 rod beats write", prog_en, 0);
    endtask

    task automatic t_txc();
        tap_shift_done = 1; tick(); idle();
        chk("R8 set", xfer_done, 1);
        eng_clr_txc = 1; tick(); idle();
        chk("R8 clear", xfer_done, 0);
        tap_shift_done = 1; eng_clr_txc = 1; tick(); idle();
        chk("R8 set wins", xfer_done, 1);
        wr(0, 8'h0C, 8'h04);
        wr(0, 8'h01, 8'h00);
        chk("R6 txc write wipes src", src_sel, 2'b00);
    endtask

    task automatic t_buf();
        logic [DW-1:0] v;
        wr(1, 8'hFF, 8'hA5);
        rd(1, v); chk("R9 full write", v, 8'hA5);
        wr(1, 8'h0F, 8'h3C);
        chk("R9 masked write", buf_par, 8'hAC);
        tap_cap_en = 1; tap_cap_data = 8'h5A;
        cpu_wr = 1; cpu_sel = 1; cpu_wmask = 8'hFF; cpu_wdata = 8'hFF;
        tick(); idle();
        chk("R10 capture wins", buf_par, 8'h5A);
    endtask

    task automatic t_sysrst();
        wr(0, 8'h0C, 8'h08);
        wr(0, 8'h02, 8'h02);
        wr(0, 8'h0C, 8'h08);
        tap_shift_done = 1; tick(); idle();
        sys_rst = 1; tick(); idle();
        chk("R11 txc/src cleared", {xfer_done, src_sel}, 0);
        chk("R11 buffer cleared", buf_par, 0);
        chk("R4 spe survives sys_rst", prog_en, 1);
    endtask

    initial begin
        idle();
        por_n = 0; cpu_sel = 0; tap_spe = 0; tap_cap_data = '0;
        repeat (3) tick();
        t_reset();
        por_n = 1;
        tick();
        t_reset();
        t_reserved();
        t_src();
        t_spe_resets();
        t_rod();
        t_txc();
        t_buf();
        t_sysrst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule